// File: doc/BRIEF.md
# Two-Zeros-in-Three Serial Detector

This block watches a serial bit stream that arrives one bit per clock. An enable strobe qualifies each bit. On every qualified bit that completes a window of three, the block raises a detect flag if exactly two of the three most recent qualified bits are 0. Every qualified bit counts toward the window, so one window overlaps the next.

The block is a Mealy machine. Three start-up states track the stream until a two-bit history exists. From then on, four steady states hold the two most recent bits. The flag is decoded from the current state and the incoming bit, so it is valid in the same cycle the bit is presented. A cycle with the strobe low consumes nothing, leaves the history unchanged and holds the flag low. An active-low asynchronous reset returns the machine to its empty start-up state.

Top module: `two_zero_detector`

## Requirements
- R1: While rst_ni is low, and on the first qualified bit after reset, detect_o is 0. Reset discards all earlier history.
- R2: detect_o is 0 in every cycle in which valid_i is 0.
- R3: The first and second qualified bits after reset never raise detect_o, whatever their values.
- R4: From the third qualified bit on, detect_o is 1 exactly when the current data_i and the two previous qualified bits contain exactly two 0s.
- R5: Cycles with valid_i low do not alter the stored history. Qualified bits that are separated by idle cycles form a window just as consecutive ones do.
- R6: detect_o is combinational in the current bit. It reflects data_i in the same cycle that valid_i is high, before the clock edge that consumes the bit.
- R7: Asserting reset in mid-stream restarts the start-up count, so the next two qualified bits again never raise detect_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies data_i this cycle |
| data_i | input | 1 | Serial data bit |
| detect_o | output | 1 | High when the window closed by this bit holds exactly two 0s |

## Verification
A corrupted history state shows up at detect_o on the very next qualified bit, because the flag decodes the stored two bits together with the incoming bit. A wrong start-up transition shows up as a flag that arrives one bit early or one bit late after reset. The bench therefore sweeps every three-bit and four-bit sequence from reset. It then runs a long pseudo-random stream with idle gaps inserted, comparing each qualified cycle against an arithmetic count of zeros. A history bit that is lost or swapped is exposed within at most two qualified bits.

// File: rtl/zd_pkg.sv
package zd_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_ONE0  = 3'd1,
    ST_ONE1  = 3'd2,
    ST_H11   = 3'd3,
    ST_H01   = 3'd4,
    ST_H10   = 3'd5,
    ST_H00   = 3'd6
  } zd_state_e;

  localparam int unsigned HIST_W = 2;

  function automatic logic has_hist(zd_state_e s);
    return (s == ST_H11) || (s == ST_H01) || (s == ST_H10) || (s == ST_H00);
  endfunction

  // {older, newer}
  function automatic logic [HIST_W-1:0] hist_bits(zd_state_e s);
    unique case (s)
      ST_H11:  return 2'b11;
      ST_H01:  return 2'b01;
      ST_H10:  return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic zd_state_e hist_state(logic [HIST_W-1:0] h);
    unique case (h)
      2'b11:   return ST_H11;
      2'b01:   return ST_H01;
      2'b10:   return ST_H10;
      default: return ST_H00;
    endcase
  endfunction

endpackage

// File: rtl/zd_next_state.sv
module zd_next_state
  import zd_pkg::*;
(
  input  zd_state_e state_i,
  input  logic      valid_i,
  input  logic      data_i,
  output zd_state_e next_o
);

  always_comb begin
    next_o = state_i;
    if (valid_i) begin
      unique case (state_i)
        ST_EMPTY: next_o = data_i ? ST_ONE1 : ST_ONE0;
        ST_ONE0:  next_o = hist_state({1'b0, data_i});
        ST_ONE1:  next_o = hist_state({1'b1, data_i});
        default:  next_o = hist_state({hist_bits(state_i)[0], data_i});
      endcase
    end
  end

endmodule

// File: rtl/zd_detect.sv
module zd_detect
  import zd_pkg::*;
(
  input  zd_state_e state_i,
  input  logic      valid_i,
  input  logic      data_i,
  output logic      detect_o
);

  logic [HIST_W:0] window;
  logic [1:0]      zero_cnt;

  always_comb begin
    window   = {hist_bits(state_i), data_i};
    zero_cnt = 2'(!window[0]) + 2'(!window[1]) + 2'(!window[2]);
    detect_o = valid_i && has_hist(state_i) && (zero_cnt == 2'd2);
  end

endmodule

// File: rtl/two_zero_detector.sv
module two_zero_detector
  import zd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic data_i,
  output logic detect_o
);

  zd_state_e state_q, state_d;

  zd_next_state u_next (
    .state_i (state_q),
    .valid_i (valid_i),
    .data_i  (data_i),
    .next_o  (state_d)
  );

  zd_detect u_det (
    .state_i  (state_q),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .detect_o (detect_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_EMPTY;
    else         state_q <= state_d;
  end

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !detect_o);

  assert_idle_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));

  assert_no_early_detect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> has_hist(state_q));

  assert_history_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_hist(state_q) |=> has_hist(state_q));

  assert_newest_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q != ST_EMPTY) |=> hist_bits(state_q)[0] == $past(data_i));

  assert_ones_no_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q == ST_H11) |-> !detect_o);

  assert_zeros_then_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_q == ST_H00 && data_i) |-> detect_o);

endmodule

// File: tb/tb_two_zero_detector.sv
module tb_two_zero_detector;

  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic data_i = 1'b0;
  logic detect_o;

  int checks = 0;
  int errors = 0;

  // bench model of the window
  int   rx_cnt = 0;
  logic h_old = 1'b0;
  logic h_new = 1'b0;

  two_zero_detector dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .data_i   (data_i),
    .detect_o (detect_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: detect_o=%b expected=%b (rx_cnt=%0d)", req, act, exp, rx_cnt);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    valid_i = 1'b1;
    data_i  = 1'b0;
    #1 check(detect_o, 1'b0, "R1");
    @(negedge clk_i);
    rst_ni  = 1'b1;
    valid_i = 1'b0;
    rx_cnt  = 0;
  endtask

  // drive one cycle, check the Mealy output before the consuming edge
  task automatic step(input logic v, input logic d);
    logic exp;
    int   z;
    @(negedge clk_i);
    valid_i = v;
    data_i  = d;
    z = int'(!h_old) + int'(!h_new) + int'(!d);
    exp = v && (rx_cnt >= 2) && (z == 2);
    #1;
    if (!v)              check(detect_o, 1'b0, "R2");
    else if (rx_cnt < 2) check(detect_o, 1'b0, "R3");
    else                 check(detect_o, exp,  "R4_R6");
    if (v) begin
      h_old  = h_new;
      h_new  = d;
      rx_cnt = rx_cnt + 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();

    // R1: the first bit after reset is quiet
    step(1'b1, 1'b0);

    // R3/R4: every 3-bit and 4-bit sequence from reset
    for (int n = 3; n <= 4; n++) begin
      for (int p = 0; p < (1 << n); p++) begin
        do_reset();
        for (int i = n - 1; i >= 0; i--) step(1'b1, p[i]);
      end
    end

    // R5: idle gaps between qualified bits
    do_reset();
    for (int p = 0; p < 16; p++) begin
      step(1'b1, p[0]);
      step(1'b0, ~p[0]);
      step(1'b0, 1'b1);
      step(1'b1, p[1]);
      step(1'b0, 1'b0);
      step(1'b1, p[2]);
      step(1'b1, p[3]);
    end

    // R7: reset mid-stream, then the start-up runs again
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    do_reset();
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);

    // long pseudo-random stream with gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], lfsr[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule